// File: doc/BRIEF.md
# Prioritized Channel-Mapped Interrupt Controller

This block collects up to 64 synchronous interrupt sources and presents them to a processor on two host lines: a fast line and a normal line. Each source has its own trigger kind (edge or level) and active sense, a latched status bit and an enable bit. Each source is also steered to one of 32 priority channels. Channels 0 and 1 feed the fast line, and channels 2 to 31 feed the normal line.

Software uses a simple word-addressed register bus. Single-source registers take a source number in the write data and set or clear one enable, or acknowledge one status. Bulk words clear many enables or statuses in one write. Further registers hold the active sense, the trigger kind, the channel of each source, the two host enables and a global enable. For each host, a read-only index register reports the winning pending source. Reads are combinational from the registered state. Writes take effect at the clock edge on which `bus_we_i` is sampled high.

Register word addresses: 0x00 global enable (bit 0); 0x01 enable-set by index; 0x02 enable-clear by index; 0x03 status acknowledge by index; 0x04 host-enable set by index; 0x05 host-enable clear by index; 0x06 host enables (read, bit 0 fast, bit 1 normal); 0x08/0x09 enables (read) and bulk enable clear (write); 0x0A/0x0B statuses (read) and bulk status clear (write); 0x0C/0x0D active sense; 0x0E/0x0F trigger kind; 0x10 to 0x1F channel map; 0x20 fast-host index; 0x21 normal-host index.

Top module: `prio_chan_intc`

## Requirements
- R1: While reset is held and after its release, the following are all 0: every enable, status, sense bit, kind bit and channel field, the global enable and both host enables. Both host lines are low, and both index registers read 0x8000_0000.
- R2: A source with kind bit 1 is edge-triggered. With sense 1, its status sets at the edge that first samples the input high after a low sample. With sense 0, it sets at the edge that first samples the input low after a high sample. The status then holds until software clears it. The opposite transition sets nothing.
- R3: A source with kind bit 0 is level-triggered. Its status sets at every edge that samples the input equal to the sense bit, so an acknowledge made while the input stays active does not clear it.
- R4: A write to 0x01 or 0x02 sets or clears only the enable of the source numbered by wdata[5:0].
- R5: A write to 0x03 clears only the status of the source numbered by wdata[5:0], unless that source sets again in the same cycle.
- R6: In bulk words 0x08+w (enable) and 0x0A+w (status), wdata bit j stands for source 32*w+j. A 1 clears that source, and a 0 leaves it unchanged.
- R7: Channel word 0x10+k/4 holds the channel of source k in bits [8*(k%4)+4 : 8*(k%4)]. Bits 7:5 of each byte are ignored on write and read as 0.
- R8: Among pending sources (status and enable both 1) on one host, the one with the lowest channel number wins. On equal channels, the lowest source number wins.
- R9: Channels 0 and 1 belong to the fast host (line `fast_irq_o`, index 0x20). Channels 2 to 31 belong to the normal host (line `norm_irq_o`, index 0x21).
- R10: A write to 0x04 or 0x05 sets or clears the enable of host wdata[0], where 1 is the normal host. A host line is high only when its host enable, the global enable and at least one pending source on that host are all 1. The index registers do not depend on the enables.
- R11: An index register reads the winning source number with bit 31 clear, or reads exactly 0x8000_0000 when no source is pending on that host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Synchronous interrupt source inputs |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i (combinational) |
| fast_irq_o | output | 1 | Fast host interrupt line |
| norm_irq_o | output | 1 | Normal host interrupt line |

## Verification
A register write, a source edge and an active level are all captured at one clock edge. Read data, the index registers and the host lines then reflect the new state right after that edge, with no further delay. The bench changes inputs one nanosecond after a falling edge and checks them at the next falling edge. Each check therefore observes the state after exactly one rising edge. A behavioural reference model is compared with both host lines and with the read data on every falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // Register word addresses
    localparam logic [7:0] A_GLB      = 8'h00;
    localparam logic [7:0] A_EN_SET   = 8'h01;
    localparam logic [7:0] A_EN_CLR   = 8'h02;
    localparam logic [7:0] A_ST_ACK   = 8'h03;
    localparam logic [7:0] A_HOST_SET = 8'h04;
    localparam logic [7:0] A_HOST_CLR = 8'h05;
    localparam logic [7:0] A_HOST_EN  = 8'h06;
    localparam logic [7:0] A_EN_BULK  = 8'h08;
    localparam logic [7:0] A_ST_BULK  = 8'h0A;
    localparam logic [7:0] A_POL      = 8'h0C;
    localparam logic [7:0] A_TYP      = 8'h0E;
    localparam logic [7:0] A_MAP      = 8'h10;
    localparam logic [7:0] A_IDX      = 8'h20;

    localparam logic [31:0] IDX_NONE  = 32'h8000_0000;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
    parameter int N_SRC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] pol_i,
    input  logic [N_SRC-1:0] typ_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] stat_o
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] stat;
    } bank_t;

    bank_t            bank_q, bank_d;
    logic [N_SRC-1:0] hit;

    // Per-source trigger detection: kind bit selects edge or level,
    // sense bit selects rising/high or falling/low.
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        logic rise, fall;
        assign rise   = src_i[k] & ~bank_q.prev[k];
        assign fall   = ~src_i[k] & bank_q.prev[k];
        assign hit[k] = typ_i[k] ? (pol_i[k] ? rise : fall)
                                 : ~(src_i[k] ^ pol_i[k]);
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.prev = src_i;
        bank_d.stat = (bank_q.stat & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stat_o = bank_q.stat;

    // R2: a status bit only becomes set when its trigger fired
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((bank_q.stat & ~$past(bank_q.stat)) & ~$past(hit)) == '0);

    // R3: an active level always leaves the status set
    a_r3_level_latches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(~typ_i & ~(src_i ^ pol_i)) & ~bank_q.stat) == '0);

    // R5: a cleared source stays clear unless it re-triggered
    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bank_q.stat & $past(clr_i) & ~$past(hit)) == '0);
endmodule

// File: rtl/intc_host_arb.sv
module intc_host_arb #(
    parameter int N_SRC = 64,
    parameter int CH_W  = 5,
    parameter int CH_LO = 0,
    parameter int CH_HI = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_SRC-1:0]               pend_i,
    input  logic [N_SRC-1:0][CH_W-1:0]     chan_i,
    output logic                           found_o,
    output logic [$clog2(N_SRC)-1:0]       win_o
);
    localparam int SW   = $clog2(N_SRC);
    localparam int N_CH = 1 << CH_W;
    localparam logic [N_CH-1:0] OWN_MASK =
        N_CH'(((64'd1 << (CH_HI + 1)) - 64'd1) & ~((64'd1 << CH_LO) - 64'd1));

    logic [CH_W-1:0] best_ch;

    // Ascending scan with strict compare: lowest channel, then lowest index.
    always_comb begin
        found_o = 1'b0;
        best_ch = '1;
        win_o   = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (pend_i[s] && OWN_MASK[chan_i[s]] &&
                (!found_o || chan_i[s] < best_ch)) begin
                found_o = 1'b1;
                best_ch = chan_i[s];
                win_o   = SW'(s);
            end
        end
    end

    // R8: the reported winner is itself pending
    a_r8_win_pending: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> pend_i[win_o]);

    // R9: the reported winner sits on a channel owned by this host
    a_r9_win_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> OWN_MASK[chan_i[win_o]]);
endmodule

// File: rtl/prio_chan_intc.sv
module prio_chan_intc #(
    parameter int N_SRC     = 64,
    parameter int CH_W      = 5,
    parameter int N_FAST_CH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_we_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             fast_irq_o,
    output logic             norm_irq_o
);
    import intc_pkg::*;

    localparam int SW    = $clog2(N_SRC);
    localparam int NWORD = N_SRC / 32;
    localparam int NMAP  = N_SRC / 4;
    localparam int N_CH  = 1 << CH_W;

    typedef struct packed {
        logic                       glb;
        logic [1:0]                 hen;
        logic [N_SRC-1:0]           en;
        logic [N_SRC-1:0]           pol;
        logic [N_SRC-1:0]           typ;
        logic [N_SRC-1:0][CH_W-1:0] chan;
    } regs_t;

    regs_t            regs_q, regs_d;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] stat;
    logic [N_SRC-1:0] pend;
    logic [1:0]       found;
    logic [SW-1:0]    win [2];
    logic [31:0]      idx [2];
    logic [1:0]       host_act;

    // ---------------- next-state logic ----------------
    always_comb begin
        regs_d  = regs_q;
        clr_vec = '0;
        if (bus_we_i) begin
            case (bus_addr_i)
                A_GLB:      regs_d.glb = bus_wdata_i[0];
                A_EN_SET:   regs_d.en[bus_wdata_i[SW-1:0]] = 1'b1;
                A_EN_CLR:   regs_d.en[bus_wdata_i[SW-1:0]] = 1'b0;
                A_ST_ACK:   clr_vec[bus_wdata_i[SW-1:0]] = 1'b1;
                A_HOST_SET: regs_d.hen[bus_wdata_i[0]] = 1'b1;
                A_HOST_CLR: regs_d.hen[bus_wdata_i[0]] = 1'b0;
                default: ;
            endcase
            for (int w = 0; w < NWORD; w++) begin
                if (bus_addr_i == A_EN_BULK + 8'(w))
                    regs_d.en[32*w +: 32] = regs_q.en[32*w +: 32] & ~bus_wdata_i;
                if (bus_addr_i == A_ST_BULK + 8'(w))
                    clr_vec[32*w +: 32] = bus_wdata_i;
                if (bus_addr_i == A_POL + 8'(w))
                    regs_d.pol[32*w +: 32] = bus_wdata_i;
                if (bus_addr_i == A_TYP + 8'(w))
                    regs_d.typ[32*w +: 32] = bus_wdata_i;
            end
            for (int m = 0; m < NMAP; m++) begin
                if (bus_addr_i == A_MAP + 8'(m)) begin
                    for (int b = 0; b < 4; b++)
                        regs_d.chan[4*m + b] = bus_wdata_i[8*b +: CH_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // ---------------- status latches ----------------
    intc_src_bank #(.N_SRC(N_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .pol_i  (regs_q.pol),
        .typ_i  (regs_q.typ),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    assign pend = stat & regs_q.en;

    // ---------------- per-host resolution ----------------
    for (genvar h = 0; h < 2; h++) begin : g_host
        localparam int LO = (h == 0) ? 0 : N_FAST_CH;
        localparam int HI = (h == 0) ? N_FAST_CH - 1 : N_CH - 1;

        intc_host_arb #(
            .N_SRC (N_SRC),
            .CH_W  (CH_W),
            .CH_LO (LO),
            .CH_HI (HI)
        ) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .pend_i  (pend),
            .chan_i  (regs_q.chan),
            .found_o (found[h]),
            .win_o   (win[h])
        );

        assign idx[h]      = found[h] ? 32'(win[h]) : IDX_NONE;
        assign host_act[h] = regs_q.glb & regs_q.hen[h] & found[h];
    end

    assign fast_irq_o = host_act[0];
    assign norm_irq_o = host_act[1];

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            A_GLB:          bus_rdata_o = {31'b0, regs_q.glb};
            A_HOST_EN:      bus_rdata_o = {30'b0, regs_q.hen};
            A_IDX:          bus_rdata_o = idx[0];
            A_IDX + 8'd1:   bus_rdata_o = idx[1];
            default: ;
        endcase
        for (int w = 0; w < NWORD; w++) begin
            if (bus_addr_i == A_EN_BULK + 8'(w)) bus_rdata_o = regs_q.en[32*w +: 32];
            if (bus_addr_i == A_ST_BULK + 8'(w)) bus_rdata_o = stat[32*w +: 32];
            if (bus_addr_i == A_POL + 8'(w))     bus_rdata_o = regs_q.pol[32*w +: 32];
            if (bus_addr_i == A_TYP + 8'(w))     bus_rdata_o = regs_q.typ[32*w +: 32];
        end
        for (int m = 0; m < NMAP; m++) begin
            if (bus_addr_i == A_MAP + 8'(m)) begin
                for (int b = 0; b < 4; b++)
                    bus_rdata_o[8*b +: CH_W] = regs_q.chan[4*m + b];
            end
        end
    end

    // R10: global enable low keeps both host lines low
    a_r10_glb_off: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.glb |-> (!fast_irq_o && !norm_irq_o));

    // R4: indexed enable-set reaches its source
    a_r4_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_EN_SET) |=> regs_q.en[$past(bus_wdata_i[SW-1:0])]);

    // R4: indexed enable-clear reaches its source
    a_r4_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == A_EN_CLR) |=> !regs_q.en[$past(bus_wdata_i[SW-1:0])]);

    // R11: an active line implies a valid index on that host
    a_r11_idx_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_irq_o |-> !idx[0][31]) and (norm_irq_o |-> !idx[1][31]));
endmodule

// File: tb/prio_chan_intc_bench.sv
`timescale 1ns/1ps
module prio_chan_intc_bench;
    localparam logic [7:0] A_GLB = 8'h00, A_EN_SET = 8'h01, A_EN_CLR = 8'h02,
        A_ST_ACK = 8'h03, A_HOST_SET = 8'h04, A_HOST_CLR = 8'h05, A_HOST_EN = 8'h06,
        A_EN_BULK = 8'h08, A_ST_BULK = 8'h0A, A_POL = 8'h0C, A_TYP = 8'h0E,
        A_MAP = 8'h10, A_IDX = 8'h20;
    localparam logic [31:0] NONE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fast, norm;

    int n_chk = 0;
    int n_fail = 0;
    bit live = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_chan_intc u_prio_chan_intc (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .fast_irq_o(fast), .norm_irq_o(norm)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_en, m_st, m_pol, m_typ, m_prv;
    logic [4:0]  m_ch [64];
    logic        m_glb;
    logic [1:0]  m_hen;

    function automatic int m_win(input int h);
        int lo = (h == 0) ? 0 : 2;
        int hi = (h == 0) ? 1 : 31;
        for (int c = lo; c <= hi; c++)
            for (int s = 0; s < 64; s++)
                if (m_st[s] && m_en[s] && int'(m_ch[s]) == c) return s;
        return -1;
    endfunction

    function automatic logic [31:0] m_idx(input int h);
        int w = m_win(h);
        return (w < 0) ? NONE : 32'(w);
    endfunction

    function automatic logic m_line(input int h);
        return m_glb && m_hen[h] && (m_win(h) >= 0);
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == A_GLB) r = {31'b0, m_glb};
        else if (a == A_HOST_EN) r = {30'b0, m_hen};
        else if (a == A_IDX) r = m_idx(0);
        else if (a == A_IDX + 8'd1) r = m_idx(1);
        else if (a == A_EN_BULK || a == A_EN_BULK + 8'd1) r = m_en[32*(a - A_EN_BULK) +: 32];
        else if (a == A_ST_BULK || a == A_ST_BULK + 8'd1) r = m_st[32*(a - A_ST_BULK) +: 32];
        else if (a == A_POL || a == A_POL + 8'd1) r = m_pol[32*(a - A_POL) +: 32];
        else if (a == A_TYP || a == A_TYP + 8'd1) r = m_typ[32*(a - A_TYP) +: 32];
        else if (a >= A_MAP && a < A_MAP + 8'd16)
            for (int b = 0; b < 4; b++) r[8*b +: 5] = m_ch[4*(a - A_MAP) + b];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_st = '0; m_pol = '0; m_typ = '0; m_prv = '0;
            m_glb = 1'b0; m_hen = '0;
            for (int s = 0; s < 64; s++) m_ch[s] = '0;
        end else begin
            logic [63:0] setv, clr;
            clr = '0;
            for (int s = 0; s < 64; s++)
                setv[s] = m_typ[s] ? (m_pol[s] ? (src[s] && !m_prv[s]) : (!src[s] && m_prv[s]))
                                   : (src[s] == m_pol[s]);
            if (we) begin
                if (addr == A_ST_ACK) clr[wdata[5:0]] = 1'b1;
                if (addr == A_ST_BULK) clr[31:0] = wdata;
                if (addr == A_ST_BULK + 8'd1) clr[63:32] = wdata;
                if (addr == A_GLB) m_glb = wdata[0];
                if (addr == A_EN_SET) m_en[wdata[5:0]] = 1'b1;
                if (addr == A_EN_CLR) m_en[wdata[5:0]] = 1'b0;
                if (addr == A_HOST_SET) m_hen[wdata[0]] = 1'b1;
                if (addr == A_HOST_CLR) m_hen[wdata[0]] = 1'b0;
                if (addr == A_EN_BULK) m_en[31:0] = m_en[31:0] & ~wdata;
                if (addr == A_EN_BULK + 8'd1) m_en[63:32] = m_en[63:32] & ~wdata;
                if (addr == A_POL) m_pol[31:0] = wdata;
                if (addr == A_POL + 8'd1) m_pol[63:32] = wdata;
                if (addr == A_TYP) m_typ[31:0] = wdata;
                if (addr == A_TYP + 8'd1) m_typ[63:32] = wdata;
                if (addr >= A_MAP && addr < A_MAP + 8'd16)
                    for (int b = 0; b < 4; b++) m_ch[4*(addr - A_MAP) + b] = wdata[8*b +: 5];
            end
            m_st = (m_st & ~clr) | setv;
            m_prv = src;
        end
    end

    // Compare model and design on every falling edge
    always @(negedge clk) begin
        if (live && !done) begin
            n_chk++;
            if (fast !== m_line(0) || norm !== m_line(1)) begin
                n_fail++;
                $display("FAIL R9 model lines: got %b%b exp %b%b", fast, norm, m_line(0), m_line(1));
            end
            n_chk++;
            if (rdata !== m_rd(addr)) begin
                n_fail++;
                $display("FAIL R7 model read @%h: got %h exp %h", addr, rdata, m_rd(addr));
            end
        end
    end

    // ---------------- directed stimulus helpers ----------------
    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); #1; we = 1'b1; addr = a; wdata = v;
        @(negedge clk); #1; we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1; addr = a; #1;
        chk(rdata, exp, tag);
    endtask

    task automatic ln_chk(input logic ef, input logic en, input string tag);
        @(negedge clk); #1;
        chk({30'b0, fast, norm}, {30'b0, ef, en}, tag);
    endtask

    task automatic set_src(input int s, input logic v);
        @(negedge clk); #1; src[s] = v;
    endtask

    task automatic pulse(input int s);
        set_src(s, 1'b1);
        set_src(s, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        live = 1;
        // R1: reset state, observed while reset is held
        rd_chk(A_IDX, NONE, "R1 fast index");
        rd_chk(A_IDX + 8'd1, NONE, "R1 normal index");
        rd_chk(A_ST_BULK, 32'h0, "R1 status");
        rd_chk(A_GLB, 32'h0, "R1 global");
        ln_chk(1'b0, 1'b0, "R1 lines");
        @(negedge clk); #1; rst_n = 1'b1;

        // Everything rising-edge, then clear statuses latched as level-low
        wr(A_POL, '1); wr(A_POL + 8'd1, '1);
        wr(A_TYP, '1); wr(A_TYP + 8'd1, '1);
        wr(A_ST_BULK, '1); wr(A_ST_BULK + 8'd1, '1);
        rd_chk(A_ST_BULK, 32'h0, "R6 bulk status clear w0");
        rd_chk(A_ST_BULK + 8'd1, 32'h0, "R6 bulk status clear w1");

        // Channel map
        for (int m = 0; m < 16; m++) wr(A_MAP + 8'(m), 32'h1F1F_1F1F);
        wr(A_MAP + 8'd1, 32'hFF1F_07E3);
        rd_chk(A_MAP + 8'd1, 32'h1F1F_0703, "R7 map fields");
        wr(A_MAP + 8'd2, 32'h1F1F_031F);   // src9 -> ch3
        wr(A_MAP + 8'd10, 32'h1F1F_0001);  // src40 -> ch1, src41 -> ch0
        wr(A_MAP + 8'd5, 32'h1F1F_1F0A);   // src20 -> ch10
        wr(A_MAP + 8'd12, 32'h1F02_1F1F);  // src50 -> ch2

        // Hosts and global
        wr(A_GLB, 32'h1);
        wr(A_HOST_SET, 32'h0);
        wr(A_HOST_SET, 32'h1);
        rd_chk(A_HOST_EN, 32'h3, "R10 host enables");

        // Enables
        wr(A_EN_SET, 32'd5); wr(A_EN_SET, 32'd9); wr(A_EN_SET, 32'd40);
        wr(A_EN_SET, 32'd41); wr(A_EN_SET, 32'd6);
        rd_chk(A_EN_BULK, 32'h0000_0260, "R4 enable set w0");
        rd_chk(A_EN_BULK + 8'd1, 32'h0000_0300, "R4 enable set w1");
        ln_chk(1'b0, 1'b0, "R10 nothing pending");
        rd_chk(A_IDX + 8'd1, NONE, "R11 empty normal");

        // Edge latching and priority
        pulse(5);
        ln_chk(1'b0, 1'b1, "R2 rising latched line");
        rd_chk(A_IDX + 8'd1, 32'd5, "R9 normal index");
        rd_chk(A_ST_BULK, 32'h0000_0020, "R2 held after input low");
        pulse(9);
        rd_chk(A_IDX + 8'd1, 32'd9, "R8 lower channel wins");
        wr(A_ST_ACK, 32'd9);
        rd_chk(A_IDX + 8'd1, 32'd5, "R5 ack by index");
        rd_chk(A_ST_BULK, 32'h0000_0020, "R5 only named source");

        wr(A_MAP + 8'd1, 32'h1F07_0703);   // src6 -> ch7 like src5
        pulse(6);
        rd_chk(A_IDX + 8'd1, 32'd5, "R8 tie lowest source");
        wr(A_ST_ACK, 32'd5);
        rd_chk(A_IDX + 8'd1, 32'd6, "R8 tie next source");

        pulse(40);
        ln_chk(1'b1, 1'b1, "R9 fast line");
        rd_chk(A_IDX, 32'd40, "R9 fast index");
        pulse(41);
        rd_chk(A_IDX, 32'd41, "R8 channel 0 first");

        // Host and global enables
        wr(A_HOST_CLR, 32'h0);
        ln_chk(1'b0, 1'b1, "R10 fast host off");
        rd_chk(A_IDX, 32'd41, "R10 index unaffected");
        wr(A_GLB, 32'h0);
        ln_chk(1'b0, 1'b0, "R10 global off");
        wr(A_GLB, 32'h1);
        ln_chk(1'b0, 1'b1, "R10 global on");
        wr(A_HOST_SET, 32'h0);

        // Falling edge source 20
        wr(A_POL, 32'hFFEF_FFFF);
        wr(A_EN_SET, 32'd20);
        set_src(20, 1'b1);
        rd_chk(A_ST_BULK, 32'h0000_0040, "R2 no latch on rise");
        set_src(20, 1'b0);
        rd_chk(A_ST_BULK, 32'h0010_0040, "R2 falling latched");

        // Level source 50
        wr(A_TYP + 8'd1, 32'hFFFB_FFFF);
        wr(A_EN_SET, 32'd50);
        set_src(50, 1'b1);
        rd_chk(A_ST_BULK + 8'd1, 32'h0004_0300, "R3 level latched");
        wr(A_ST_ACK, 32'd50);
        rd_chk(A_ST_BULK + 8'd1, 32'h0004_0300, "R3 relatch while active");
        rd_chk(A_IDX + 8'd1, 32'd50, "R9 channel 2 normal");
        set_src(50, 1'b0);
        wr(A_ST_ACK, 32'd50);
        rd_chk(A_ST_BULK + 8'd1, 32'h0000_0300, "R3 clears when idle");

        // Bulk and indexed enable clear
        wr(A_EN_BULK, 32'h0);
        rd_chk(A_EN_BULK, 32'h0010_0260, "R6 zero bits no effect");
        wr(A_EN_BULK, 32'h0000_0020);
        rd_chk(A_EN_BULK, 32'h0010_0240, "R6 bulk enable clear");
        wr(A_EN_CLR, 32'd9);
        rd_chk(A_EN_BULK, 32'h0010_0040, "R4 enable clear by index");
        wr(A_ST_BULK + 8'd1, 32'h0);
        rd_chk(A_ST_BULK + 8'd1, 32'h0000_0300, "R6 status zero bits");

        // Nothing pending
        wr(A_EN_BULK, '1);
        wr(A_EN_BULK + 8'd1, '1);
        rd_chk(A_IDX, NONE, "R11 fast none");
        rd_chk(A_IDX + 8'd1, NONE, "R11 normal none");
        ln_chk(1'b0, 1'b0, "R11 lines low");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule